// File: doc/BRIEF.md
# Dwell-Time Trigger Generator

This block issues the trigger that makes a multichannel scaler latch its counters. Each trigger comes from exactly one selected source. The first is an external trigger line, which is asynchronous to the system clock. The second is an internal periodic timer whose dwell period is set in whole microseconds. The third is a one-shot strobe written by the host. Every trigger appears as a pulse one clock cycle wide on `trig_out`. While the downstream event path reports busy, triggers are dropped.

The periodic timer counts microsecond ticks, which a prescaler makes by dividing the system clock by `TICK_DIV`. The period register holds the dwell time minus one, in microseconds. It is clamped to `PERIOD_MAX`, which by default gives a 4000 s ceiling. A free-running time-tag counter counts clock cycles. On each trigger the block copies it to `tag_out`, either in full or cut down to its lower half.

Top module: `dwell_trig_gen`

## Requirements
- R1: While reset is held and after it is released, `trig_out` is 0 and `tag_out` is 0 until the first trigger.
- R2: `src_sel` picks the source: 2'b00 external, 2'b01 periodic timer, 2'b10 software strobe, 2'b11 none. An event from a source that is not selected produces no pulse.
- R3: With the external source selected, the line passes through `SYNC_STAGES` synchronizer flops and then an edge detector. Each low-to-high transition gives exactly one pulse, however long the line stays high. `trig_out` is high in the cycle after clock edge e+`SYNC_STAGES`, where e is the first edge that samples the line high.
- R4: With the software source selected, a `sw_trig_wr` strobe sampled at edge e makes `trig_out` high in the cycle after edge e.
- R5: With the timer selected and the stored period P, consecutive pulses are exactly (P+1)·`TICK_DIV` clock cycles apart.
- R6: The timer and the prescaler restart from zero at the edge that first samples the timer selected, and at the edge that samples `period_wr`. The next pulse follows that edge by (P+1)·`TICK_DIV` cycles, and any count already in progress is discarded.
- R7: A written period above `PERIOD_MAX` is stored as `PERIOD_MAX`. A value at or below it is stored unchanged.
- R8: A trigger whose source event falls in a cycle where `busy_in` is high is discarded, not deferred.
- R9: The tag counter starts at `TAG_INIT` at reset and adds one on every clock edge. At a trigger, `tag_out` is loaded with the counter value of the cycle in which the trigger was decided. That value is `TAG_INIT` + e − 1 for a pulse raised at the e-th edge after reset.
- R10: When `tag_wide` is 1 at the capture edge, all `TAG_W` bits are kept. When it is 0, the upper half of `tag_out` is 0 and the lower half is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Trigger source select |
| ext_trig_in | input | 1 | Asynchronous external trigger line |
| sw_trig_wr | input | 1 | Host one-shot trigger strobe |
| period_wr | input | 1 | Period register write strobe |
| period_wdata | input | PERIOD_W | Dwell period in microseconds minus one |
| tag_wide | input | 1 | 1: full-width tag, 0: lower-half tag |
| busy_in | input | 1 | Downstream busy, suppresses triggers |
| trig_out | output | 1 | Single-cycle trigger pulse |
| tag_out | output | TAG_W | Time tag captured at the last trigger |

## Verification
The scoreboard predicts the exact edge of every pulse, so a timer that is off by one tick or one cycle is caught. A timer that ignores a period write while counting gives itself away through a stale pulse at the old period. A clamp that truncates instead of saturating yields an interval of the wrong length. The external line is held high for many cycles and driven while other sources are selected; a level-sensitive detector would repeat pulses, and loose gating would let a foreign event through. The tag counter is started just below the 32-bit boundary, so a narrow tag that keeps its upper bits, or a tag sampled one cycle late, differs from the prediction. A busy-suppressed strobe is followed by a quiet window, which exposes any trigger that is deferred rather than dropped.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  typedef enum logic [1:0] {
    SRC_EXT   = 2'b00,
    SRC_TIMER = 2'b01,
    SRC_SOFT  = 2'b10,
    SRC_OFF   = 2'b11
  } trig_src_e;

  // Saturate a requested period at the ceiling.
  function automatic logic [63:0] dtg_clamp(input logic [63:0] req,
                                            input logic [63:0] ceil);
    return (req > ceil) ? ceil : req;
  endfunction

  // Dwell interval in clock cycles for a stored period.
  function automatic logic [63:0] dtg_interval(input logic [63:0] period,
                                               input logic [63:0] div);
    return (period + 64'd1) * div;
  endfunction

endpackage

// File: rtl/dtg_us_tick.sv
module dtg_us_tick #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] div_cnt;

  assign tick = (div_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_cnt <= '0;
    else if (clr)     div_cnt <= '0;
    else if (tick)    div_cnt <= '0;
    else              div_cnt <= div_cnt + CW'(1);
  end

  // R5
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= LAST);

  // R5
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/dtg_dwell_timer.sv
module dtg_dwell_timer
  import dtg_pkg::*;
#(
  parameter int               PERIOD_W   = 32,
  parameter logic [PERIOD_W-1:0] PERIOD_MAX = PERIOD_W'(64'd3999999999)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                tick,
  input  logic                wr,
  input  logic [PERIOD_W-1:0] wdata,
  output logic                restart,
  output logic                expire
);
  logic [PERIOD_W-1:0] period_q;
  logic [PERIOD_W-1:0] us_cnt;
  logic                en_q;
  logic                at_end;

  assign restart = (en && !en_q) || wr;
  assign at_end  = (us_cnt == period_q);
  assign expire  = en && !restart && tick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      en_q     <= 1'b0;
    end else begin
      en_q <= en;
      if (wr)
        period_q <= PERIOD_W'(dtg_clamp(64'(wdata), 64'(PERIOD_MAX)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              us_cnt <= '0;
    else if (!en || restart) us_cnt <= '0;
    else if (tick)           us_cnt <= at_end ? '0 : us_cnt + PERIOD_W'(1);
  end

  // R7
  period_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_q <= PERIOD_MAX);

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    us_cnt <= period_q);

  // R6
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (us_cnt == '0));

endmodule

// File: rtl/dtg_ext_edge.sv
module dtg_ext_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] && !prev_q;

  // R3
  ext_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/dwell_trig_gen.sv
module dwell_trig_gen
  import dtg_pkg::*;
#(
  parameter int                  TICK_DIV    = 100,
  parameter int                  PERIOD_W    = 32,
  parameter logic [PERIOD_W-1:0] PERIOD_MAX  = PERIOD_W'(64'd3999999999),
  parameter int                  SYNC_STAGES = 2,
  parameter int                  TAG_W       = 64,
  parameter logic [TAG_W-1:0]    TAG_INIT    = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          src_sel,
  input  logic                ext_trig_in,
  input  logic                sw_trig_wr,
  input  logic                period_wr,
  input  logic [PERIOD_W-1:0] period_wdata,
  input  logic                tag_wide,
  input  logic                busy_in,
  output logic                trig_out,
  output logic [TAG_W-1:0]    tag_out
);
  localparam int HALF = TAG_W / 2;

  trig_src_e  src;
  logic       sel_ext, sel_tmr, sel_sw;
  logic       ext_rise;
  logic       us_tick;
  logic       tmr_restart;
  logic       tmr_expire;
  logic       cand;
  logic       fire;
  logic [TAG_W-1:0] tag_cnt;

  assign src     = trig_src_e'(src_sel);
  assign sel_ext = (src == SRC_EXT);
  assign sel_tmr = (src == SRC_TIMER);
  assign sel_sw  = (src == SRC_SOFT);

  dtg_ext_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (ext_trig_in),
    .rise    (ext_rise)
  );

  dtg_us_tick #(.DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_restart),
    .tick  (us_tick)
  );

  dtg_dwell_timer #(.PERIOD_W(PERIOD_W), .PERIOD_MAX(PERIOD_MAX)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (sel_tmr),
    .tick    (us_tick),
    .wr      (period_wr),
    .wdata   (period_wdata),
    .restart (tmr_restart),
    .expire  (tmr_expire)
  );

  assign cand = (sel_ext && ext_rise) || tmr_expire || (sel_sw && sw_trig_wr);
  assign fire = cand && !busy_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_cnt <= TAG_INIT;
    else        tag_cnt <= tag_cnt + TAG_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_out <= 1'b0;
      tag_out  <= '0;
    end else begin
      trig_out <= fire;
      if (fire)
        tag_out <= tag_wide ? tag_cnt : {{(TAG_W-HALF){1'b0}}, tag_cnt[HALF-1:0]};
    end
  end

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_in |=> !trig_out);

  // R3
  ext_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ext && ext_rise && !busy_in) |=> trig_out);

  // R2
  timer_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_tmr |-> !tmr_expire);

  // R10
  narrow_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && !$past(tag_wide)) |-> (tag_out[TAG_W-1:HALF] == '0));

endmodule

// File: tb/sim_dwell_trig_gen.sv
module sim_dwell_trig_gen;
  localparam int          DIV   = 4;
  localparam logic [31:0] PMAX  = 32'd20;
  localparam logic [63:0] TINIT = 64'h0000_0001_FFFF_FF80;

  typedef struct {
    int    at;
    bit    wide;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  src_sel = 2'b11;
  logic        ext_trig_in = 1'b0;
  logic        sw_trig_wr = 1'b0;
  logic        period_wr = 1'b0;
  logic [31:0] period_wdata = '0;
  logic        tag_wide = 1'b1;
  logic        busy_in = 1'b0;
  logic        trig_out;
  logic [63:0] tag_out;

  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  string ctx = "R2";
  exp_t  sb[$];

  always #10 clk = ~clk;

  dwell_trig_gen #(
    .TICK_DIV(DIV), .PERIOD_W(32), .PERIOD_MAX(PMAX),
    .SYNC_STAGES(2), .TAG_W(64), .TAG_INIT(TINIT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ext_trig_in(ext_trig_in),
    .sw_trig_wr(sw_trig_wr), .period_wr(period_wr), .period_wdata(period_wdata),
    .tag_wide(tag_wide), .busy_in(busy_in), .trig_out(trig_out), .tag_out(tag_out)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every pulse.
  always @(negedge clk) begin
    if (rst_n && trig_out) begin
      if (sb.size() == 0) begin
        check(1'b0, ctx, "unexpected pulse at cycle", cyc, -1);
      end else begin
        exp_t e;
        logic [63:0] et;
        e  = sb.pop_front();
        et = TINIT + 64'(cyc) - 64'd1;
        if (!e.wide) et = {32'b0, et[31:0]};
        check(cyc == e.at, e.req, "pulse cycle", cyc, e.at);
        check(tag_out == et, e.req, "captured tag", tag_out, et);
      end
    end
  end

  task automatic expect_at(input int at, input string req);
    exp_t e;
    e.at = at; e.wide = tag_wide; e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input string req);
    idle(8);
    check(sb.size() == 0, req, "missing pulses", sb.size(), 0);
    sb.delete();
  endtask

  task automatic sw_strobe(input bit expect_it, input string req);
    @(negedge clk);
    sw_trig_wr = 1'b1;
    if (expect_it) expect_at(cyc + 1, req);
    @(negedge clk);
    sw_trig_wr = 1'b0;
  endtask

  task automatic set_src(input logic [1:0] s, output int edge_at);
    @(negedge clk);
    src_sel = s;
    edge_at = cyc + 1;
  endtask

  task automatic write_period(input logic [31:0] v, output int edge_at);
    @(negedge clk);
    period_wr = 1'b1;
    period_wdata = v;
    edge_at = cyc + 1;
    @(negedge clk);
    period_wr = 1'b0;
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e;
    int w;
    idle(3);
    // R1 reset values
    check(trig_out == 1'b0, "R1", "trig_out in reset", trig_out, 0);
    check(tag_out == 64'd0, "R1", "tag_out in reset", tag_out, 0);
    rst_n = 1'b1;
    idle(5);
    check(trig_out == 1'b0 && tag_out == 64'd0, "R1", "idle after reset", tag_out, 0);

    // R4 software strobes
    ctx = "R4";
    src_sel = 2'b10;
    sw_strobe(1'b1, "R4");
    idle(4);
    sw_strobe(1'b1, "R4");
    drain("R4");

    // R2 foreign sources ignored
    ctx = "R2";
    src_sel = 2'b00;
    sw_strobe(1'b0, "R2");
    drain("R2");
    src_sel = 2'b10;
    @(negedge clk); ext_trig_in = 1'b1;
    idle(6);
    ext_trig_in = 1'b0;
    idle(6);
    src_sel = 2'b11;
    sw_strobe(1'b0, "R2");
    drain("R2");

    // R3 external: one pulse per rising edge, SYNC_STAGES edges later
    ctx = "R3";
    src_sel = 2'b00;
    idle(4);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      ext_trig_in = 1'b1;
      expect_at(cyc + 1 + 2, "R3");
      idle(12);
      ext_trig_in = 1'b0;
      idle(5);
    end
    drain("R3");

    // R8 busy drops, does not defer
    ctx = "R8";
    src_sel = 2'b10;
    busy_in = 1'b1;
    sw_strobe(1'b0, "R8");
    idle(2);
    busy_in = 1'b0;
    drain("R8");
    sw_strobe(1'b1, "R8");
    drain("R8");

    // R5 periodic interval, R6 restart on enable
    ctx = "R5";
    src_sel = 2'b11;
    write_period(32'd2, w);
    set_src(2'b01, e);
    for (int k = 1; k <= 3; k++) expect_at(e + k * 12, "R6");
    wait_cyc(e + 40);
    @(negedge clk); src_sel = 2'b11;
    drain("R5");

    // R6 restart on write while counting
    ctx = "R6";
    set_src(2'b01, e);
    expect_at(e + 12, "R5");
    expect_at(e + 24, "R5");
    wait_cyc(e + 30);
    write_period(32'd5, w);
    expect_at(w + 24, "R6");
    expect_at(w + 48, "R6");
    wait_cyc(w + 50);
    @(negedge clk); src_sel = 2'b11;
    drain("R6");

    // R7 clamp
    ctx = "R7";
    write_period(32'd1000, w);
    set_src(2'b01, e);
    expect_at(e + 84, "R7");
    expect_at(e + 168, "R7");
    wait_cyc(e + 170);
    @(negedge clk); src_sel = 2'b11;
    drain("R7");

    // R9, R10 tag formats past the 32-bit boundary
    ctx = "R10";
    src_sel = 2'b10;
    tag_wide = 1'b1;
    sw_strobe(1'b1, "R9");
    drain("R9");
    check(tag_out[63:32] != 32'd0, "R10", "wide tag upper half", tag_out[63:32], 2);
    @(negedge clk); tag_wide = 1'b0;
    sw_strobe(1'b1, "R10");
    drain("R10");
    check(tag_out[63:32] == 32'd0, "R10", "narrow tag upper half", tag_out[63:32], 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule